// File: doc/BRIEF.md
# Serial Memory Power State Controller

This block keeps track of the power condition of a serial memory device and tells the command decoder when it may act on a command. After a power-on reset it holds a start-up lockout in which every access is ignored. It then settles in standby, where all commands are accepted. A decoded enter-sleep strobe (opcode B9h, one byte, no address or data) takes the device through a timed entry window into sleep. In sleep only a decoded wake strobe (opcode ABh, one byte) is honoured. That strobe starts a timed exit window that ends in standby.

Each window is measured in cycles of a free-running system clock, and each has its own length parameter. Every window starts at the clock edge that first samples chip select high after the command's transaction. The decoder uses `cmd_accept` to gate all opcodes and `wake_only` to gate everything except wake. `regs_on` tells the power circuitry whether the internal regulators must be running. Chip select must stay high for the whole exit window. A transaction started inside that window is ignored and raises a sticky `proto_err` flag, and the window still ends on time. Losing power while asleep is modelled by reset, which always restarts in the lockout and never in sleep.

Top module: `pwr_state_ctrl`

## Requirements
- R1: During reset, and for LOCKOUT_CYCLES rising clock edges after `rst_n` goes high, `cmd_accept` is 0, `wake_only` is 0 and `regs_on` is 1. From the next sample onward `cmd_accept` is 1. `cmd_accept` and `wake_only` are never 1 together.
- R2: Chip-select activity and sleep or wake strobes during the lockout are ignored. When the lockout ends the block is in standby with `proto_err` at 0.
- R3: A `sleep_cmd` strobe sampled with `cs_n` low in standby changes no output while `cs_n` stays low. At the first edge that samples `cs_n` high, `cmd_accept` goes to 0 and `wake_only` goes to 1.
- R4: `regs_on` stays 1 through the ENTRY_CYCLES edges that follow that chip-select edge and is 0 after the next one.
- R5: From sleep entry until a wake is honoured, `cmd_accept` stays 0. Further `sleep_cmd` strobes are ignored. A `wake_cmd` strobe that arrives before `regs_on` has dropped is also ignored.
- R6: A `wake_cmd` strobe sampled with `cs_n` low in sleep takes effect at the first edge that samples `cs_n` high. From that edge `regs_on` is 1 and `wake_only` is 0. `cmd_accept` stays 0 through the next EXIT_CYCLES edges and becomes 1 after the one that follows.
- R7: If `cs_n` is sampled low during the exit window, `proto_err` becomes 1 and stays 1 until the next exit window starts or a reset occurs. The exit timing of R6 is unchanged.
- R8: A `wake_cmd` strobe in standby has no effect on any output.
- R9: A reset applied while asleep returns the block to the R1 lockout, followed by standby rather than sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low power-on reset |
| cs_n | input | 1 | Chip-select level (low = transaction active), already synchronised |
| sleep_cmd | input | 1 | One-cycle strobe: enter-sleep opcode decoded in this transaction |
| wake_cmd | input | 1 | One-cycle strobe: wake opcode decoded in this transaction |
| cmd_accept | output | 1 | Decoder may act on any command |
| wake_only | output | 1 | Decoder may act on the wake command only |
| regs_on | output | 1 | Internal regulators must be powered |
| proto_err | output | 1 | Sticky: chip select went low during the exit window |

## Verification
A wrong internal state shows at the flag outputs within one clock of the edge at which it goes wrong. The outputs are decoded straight from the state register, so a state that is off by a cycle moves one of them by the same cycle. Window length errors therefore appear as a flag that flips one sample early or late. The bench probes each window on both sides of its boundary, once on the last sample before the change and once on the first sample after it. A strobe that is wrongly honoured shows within one edge of its chip-select rise. It appears as a dropped `regs_on` or `cmd_accept`, or as a window that starts where none should.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_LOCKOUT     = 3'd0,
    PS_STANDBY     = 3'd1,
    PS_SLEEP_ARMED = 3'd2,
    PS_ENTERING    = 3'd3,
    PS_ASLEEP      = 3'd4,
    PS_WAKE_ARMED  = 3'd5,
    PS_WAKING      = 3'd6
  } pwr_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // bits needed to hold 0 .. n-1
  function automatic int unsigned ctr_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // a window of n edges is counted down from n-1 to 0
  function automatic int unsigned reload_of(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic logic accept_of(input pwr_state_e s);
    return (s == PS_STANDBY) || (s == PS_SLEEP_ARMED);
  endfunction

  function automatic logic wake_gate_of(input pwr_state_e s);
    return (s == PS_ENTERING) || (s == PS_ASLEEP);
  endfunction

  function automatic logic regs_of(input pwr_state_e s);
    return (s != PS_ASLEEP) && (s != PS_WAKE_ARMED);
  endfunction

endpackage

// File: rtl/pwr_cs_edge.sv
module pwr_cs_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic cs_rise
);
  logic cs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_q <= 1'b1;
    else        cs_q <= cs_n;
  end

  assign cs_rise = cs_n & ~cs_q;
endmodule

// File: rtl/pwr_interval_timer.sv
module pwr_interval_timer #(
  parameter int unsigned    CW       = 8,
  parameter logic [CW-1:0]  RST_LOAD = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= RST_LOAD;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_state_pkg::*;
#(
  parameter int unsigned CW           = 8,
  parameter int unsigned ENTRY_CYCLES = 4,
  parameter int unsigned EXIT_CYCLES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          cs_rise,
  input  logic          sleep_cmd,
  input  logic          wake_cmd,
  input  logic          tmr_zero,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          err_set,
  output logic          err_clr,
  output pwr_state_e    state
);
  localparam logic [CW-1:0] ENTRY_LOAD = CW'(reload_of(ENTRY_CYCLES));
  localparam logic [CW-1:0] EXIT_LOAD  = CW'(reload_of(EXIT_CYCLES));

  pwr_state_e state_nx;
  logic       sleep_go;
  logic       wake_go;

  // strobes count only while a transaction is open
  assign sleep_go = sleep_cmd & ~cs_n;
  assign wake_go  = wake_cmd  & ~cs_n;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    err_set  = 1'b0;
    err_clr  = 1'b0;
    unique case (state)
      PS_LOCKOUT:     if (tmr_zero) state_nx = PS_STANDBY;
      PS_STANDBY:     if (sleep_go) state_nx = PS_SLEEP_ARMED;
      PS_SLEEP_ARMED: if (cs_rise) begin
        state_nx = PS_ENTERING;
        tmr_load = 1'b1;
        tmr_val  = ENTRY_LOAD;
      end
      PS_ENTERING:    if (tmr_zero) state_nx = PS_ASLEEP;
      PS_ASLEEP:      if (wake_go) state_nx = PS_WAKE_ARMED;
      PS_WAKE_ARMED:  if (cs_rise) begin
        state_nx = PS_WAKING;
        tmr_load = 1'b1;
        tmr_val  = EXIT_LOAD;
        err_clr  = 1'b1;
      end
      PS_WAKING: begin
        err_set = ~cs_n;
        if (tmr_zero) state_nx = PS_STANDBY;
      end
      default:        state_nx = PS_LOCKOUT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_LOCKOUT;
    else        state <= state_nx;
  end
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int unsigned LOCKOUT_CYCLES = 40000,
  parameter int unsigned ENTRY_CYCLES   = 300,
  parameter int unsigned EXIT_CYCLES    = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sleep_cmd,
  input  logic wake_cmd,
  output logic cmd_accept,
  output logic wake_only,
  output logic regs_on,
  output logic proto_err
);
  localparam int unsigned LONGEST = max3(LOCKOUT_CYCLES, ENTRY_CYCLES, EXIT_CYCLES);
  localparam int unsigned CW      = ctr_width(LONGEST);
  localparam logic [CW-1:0] LOCK_LOAD = CW'(reload_of(LOCKOUT_CYCLES));

  logic          cs_rise;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_zero;
  logic          err_set;
  logic          err_clr;
  pwr_state_e    state;

  pwr_cs_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .cs_rise (cs_rise)
  );

  pwr_interval_timer #(.CW(CW), .RST_LOAD(LOCK_LOAD)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_zero)
  );

  pwr_state_fsm #(
    .CW           (CW),
    .ENTRY_CYCLES (ENTRY_CYCLES),
    .EXIT_CYCLES  (EXIT_CYCLES)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .cs_rise   (cs_rise),
    .sleep_cmd (sleep_cmd),
    .wake_cmd  (wake_cmd),
    .tmr_zero  (tmr_zero),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .err_set   (err_set),
    .err_clr   (err_clr),
    .state     (state)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       proto_err <= 1'b0;
    else if (err_clr) proto_err <= 1'b0;
    else if (err_set) proto_err <= 1'b1;
  end

  assign cmd_accept = accept_of(state);
  assign wake_only  = wake_gate_of(state);
  assign regs_on    = regs_of(state);
endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk #(
  parameter int unsigned ENTRY_CYCLES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic cs_rise,
  input logic tmr_zero,
  input logic cmd_accept,
  input logic wake_only,
  input logic regs_on,
  input logic proto_err
);
  int unsigned ent_run;

  // consecutive samples spent in the entry window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ent_run <= 0;
    else if (wake_only && regs_on) ent_run <= ent_run + 1;
    else                           ent_run <= 0;
  end

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_accept, wake_only}));

  a_r3_entry_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_only) |-> $past(cs_rise));

  a_r4_entry_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(regs_on) |-> (ent_run == ENTRY_CYCLES));

  a_r5_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!regs_on && !cs_rise) |=> !regs_on);

  a_r6_wake_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(regs_on) |-> $past(cs_rise));

  a_r6_accept_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_accept) |-> $past(tmr_zero));

  a_r7_err_from_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(proto_err) |-> ($past(!cs_n) && $past(regs_on) &&
                          !$past(cmd_accept) && !$past(wake_only)));
endmodule

bind pwr_state_ctrl pwr_state_chk #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .cs_rise    (cs_rise),
  .tmr_zero   (tmr_zero),
  .cmd_accept (cmd_accept),
  .wake_only  (wake_only),
  .regs_on    (regs_on),
  .proto_err  (proto_err)
);

// File: tb/pwr_state_ctrl_tb.sv
module pwr_state_ctrl_tb;
  localparam int LOCK  = 12;
  localparam int ENTRY = 6;
  localparam int EXIT  = 20;

  logic clk = 1'b0;
  logic rst_n, cs_n, sleep_cmd, wake_cmd;
  logic cmd_accept, wake_only, regs_on, proto_err;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  pwr_state_ctrl #(
    .LOCKOUT_CYCLES (LOCK),
    .ENTRY_CYCLES   (ENTRY),
    .EXIT_CYCLES    (EXIT)
  ) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sleep_cmd  (sleep_cmd),
    .wake_cmd   (wake_cmd),
    .cmd_accept (cmd_accept),
    .wake_only  (wake_only),
    .regs_on    (regs_on),
    .proto_err  (proto_err)
  );

  // expected flags, t = samples since chip select went high
  function automatic bit exp_regs_entering(input int t);
    return t <= ENTRY;
  endfunction
  function automatic bit exp_accept_waking(input int t);
    return t > EXIT;
  endfunction
  function automatic bit exp_accept_lockout(input int t);
    return t >= LOCK;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic send(input bit is_sleep);
    cs_n = 1'b0; tick();
    if (is_sleep) sleep_cmd = 1'b1; else wake_cmd = 1'b1;
    tick();
    sleep_cmd = 1'b0; wake_cmd = 1'b0;
    tick();
    cs_n = 1'b1;
  endtask

  task automatic enter_sleep_checked(input string tag);
    send(1'b1);
    for (int t = 1; t <= ENTRY + 1; t++) begin
      tick();
      chk({tag, " regs_on entry window"}, regs_on, exp_regs_entering(t));
    end
    chk({tag, " wake_only in sleep"}, wake_only, 1'b1);
    chk({tag, " cmd_accept in sleep"}, cmd_accept, 1'b0);
  endtask

  task automatic wake_checked(input bit glitch, input int g);
    send(1'b0);
    for (int t = 1; t <= EXIT + 1; t++) begin
      tick();
      if (t == 1) begin
        chk("R6 regs_on at wake start", regs_on, 1'b1);
        chk("R6 wake_only cleared", wake_only, 1'b0);
        chk("R7 proto_err cleared at wake start", proto_err, 1'b0);
      end
      if (glitch && t == g) cs_n = 1'b0;
      if (glitch && t == g + 1) begin
        cs_n = 1'b1;
        chk("R7 proto_err set by cs low", proto_err, 1'b1);
      end
      if (t == EXIT || t == EXIT + 1)
        chk("R6 cmd_accept exit window", cmd_accept, exp_accept_waking(t));
    end
    chk("R7 proto_err held in standby", proto_err, glitch);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; cs_n = 1'b1; sleep_cmd = 1'b0; wake_cmd = 1'b0;
    repeat (3) tick();
    chk("R1 reset cmd_accept", cmd_accept, 1'b0);
    chk("R1 reset regs_on", regs_on, 1'b1);
    chk("R1 reset wake_only", wake_only, 1'b0);
    chk("R1 reset proto_err", proto_err, 1'b0);

    // lockout with activity inside it (R2)
    rst_n = 1'b1;
    tick(); cs_n = 1'b0;
    tick(); sleep_cmd = 1'b1;
    tick(); sleep_cmd = 1'b0; wake_cmd = 1'b1;
    tick(); wake_cmd = 1'b0; cs_n = 1'b1;
    for (int t = 4; t < LOCK - 1; t++) tick();
    chk("R1 lockout last sample", cmd_accept, exp_accept_lockout(LOCK - 1));
    tick();
    chk("R1 standby after lockout", cmd_accept, exp_accept_lockout(LOCK));
    chk("R2 no sleep from lockout", regs_on, 1'b1);
    chk("R2 wake_only after lockout", wake_only, 1'b0);
    chk("R2 proto_err after lockout", proto_err, 1'b0);

    // R8: wake in standby ignored
    send(1'b0);
    repeat (EXIT + 2) tick();
    chk("R8 cmd_accept after stray wake", cmd_accept, 1'b1);
    chk("R8 regs_on after stray wake", regs_on, 1'b1);
    chk("R8 wake_only after stray wake", wake_only, 1'b0);

    // R3: armed sleep waits for chip select to rise
    cs_n = 1'b0; tick();
    sleep_cmd = 1'b1; tick();
    sleep_cmd = 1'b0;
    repeat (4) tick();
    chk("R3 accept while armed", cmd_accept, 1'b1);
    chk("R3 wake_only while armed", wake_only, 1'b0);
    cs_n = 1'b1; tick();
    chk("R3 accept drops at cs rise", cmd_accept, 1'b0);
    chk("R3 wake_only at cs rise", wake_only, 1'b1);
    for (int t = 2; t <= ENTRY + 1; t++) begin
      tick();
      chk("R4 regs_on entry window", regs_on, exp_regs_entering(t));
    end

    // R5: extra sleep strobes in sleep
    send(1'b1); repeat (3) tick();
    chk("R5 sleep strobe ignored regs_on", regs_on, 1'b0);
    chk("R5 sleep strobe ignored accept", cmd_accept, 1'b0);
    wake_checked(1'b0, 0);

    // constrained random sleep/wake rounds
    for (int i = 0; i < 12; i++) begin
      int idle, extra, g;
      bit glitch;
      idle = $urandom % 5;
      repeat (idle) tick();
      chk("R6 standby before round", cmd_accept, 1'b1);
      enter_sleep_checked("R4");
      extra = $urandom % 3;
      for (int k = 0; k < extra; k++) begin
        send(1'b1); tick();
        chk("R5 regs_on stays off", regs_on, 1'b0);
        chk("R5 cmd_accept stays off", cmd_accept, 1'b0);
      end
      glitch = ($urandom % 2) == 1;
      g = 2 + ($urandom % (EXIT - 6));
      wake_checked(glitch, g);
    end

    // R5: wake during the entry window is ignored
    send(1'b1); tick();
    send(1'b0); tick();
    tick(); tick();
    chk("R5 asleep despite early wake", regs_on, 1'b0);
    repeat (EXIT + 3) tick();
    chk("R5 early wake not honoured regs_on", regs_on, 1'b0);
    chk("R5 early wake not honoured accept", cmd_accept, 1'b0);
    wake_checked(1'b0, 0);

    // R9: reset while asleep
    enter_sleep_checked("R9");
    rst_n = 1'b0; tick(); tick();
    rst_n = 1'b1;
    for (int t = 1; t < LOCK; t++) tick();
    chk("R9 lockout after reset in sleep", cmd_accept, exp_accept_lockout(LOCK - 1));
    chk("R9 regs_on during lockout", regs_on, 1'b1);
    tick();
    chk("R9 standby after lockout", cmd_accept, exp_accept_lockout(LOCK));
    chk("R9 not asleep", wake_only, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule